// File: doc/BRIEF.md
# Doubleword Memory Access Sequencer

This block performs a 64-bit floating-point load or store as two separate 32-bit memory transactions. Each word address is translated through a small internal page table of 8 KB pages. Every entry holds valid, writable, referenced and dirty flags. The caller issues a one-cycle start pulse with a command, a byte address and, for a store, a 64-bit value. The block then drives a 32-bit request/ready memory port. It finishes with either a one-cycle done pulse or a one-cycle fault pulse, which carries a fault code and the address of the word that faulted.

Side effects on the page table follow a fixed order:
- A load marks a page referenced as soon as a read from that page succeeds. If the second word then faults, the first page keeps its referenced flag.
- A store translates both words and marks both pages dirty before any write is issued. If the second page is invalid or read-only, the first page stays dirty and no memory write takes place.

The load result is committed only when both halves have been read. The word at the lower address carries the most significant 32 bits of the value. The two store writes are independent transactions and are not locked together.

A separate maintenance port loads a page-table entry, which sets its valid and writable flags and clears its referenced and dirty flags. A read port shows any entry's flags.

Top module: `dword_xfer_seq`

## Requirements
- R1: A load reads the word at the given address and then the word at address+4. The result is {first word, second word}, so the lower address holds bits 63:32. `rdata` changes only in the cycle where `done` is high.
- R2: A store writes `wdata[63:32]` to the given address and then `wdata[31:0]` to address+4, as two separate write transactions. `done` pulses after the second write completes. `mem_addr`, `mem_we` and `mem_wdata` stay stable while a request waits for `mem_ready`.
- R3: Every completed memory read sets the referenced flag of the page it read from.
- R4: When a load's first word reads successfully and its second word's page is invalid, the load ends with a fault, not `done`. The first page stays referenced and `rdata` keeps its previous value.
- R5: A store sets the dirty flags of both pages before either write. If the second page is invalid or read-only, the first page is left dirty, the second page is not dirty, and no write is issued.
- R6: An access to a page that is not valid, or whose page number is 16 or above, faults with code 2 (page-invalid). `fault_addr` gives the word address that faulted.
- R7: A store to a valid page that is not writable faults with code 3 (page-read-only). A load from such a page succeeds.
- R8: An address whose bits 1:0 are not zero faults with code 1 (alignment). It issues no memory request and changes no page-table flag.
- R9: `done` and `fault` are one-cycle pulses, are never high together, and `fault_code` is non-zero whenever `fault` is high.
- R10: A start pulse that arrives while an operation is in progress is ignored.
- R11: A maintenance write sets an entry's valid and writable flags and clears its referenced and dirty flags. `pt_rd_flags` reports {valid, writable, referenced, dirty} in bits 3..0.
- R12: After reset `done`, `fault` and `mem_req` are low and every page-table entry reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmd_store | input | 1 | 1 = store, 0 = load |
| addr | input | 32 | Byte address of the doubleword |
| wdata | input | 64 | Store value |
| done | output | 1 | Successful completion pulse |
| rdata | output | 64 | Load result |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 alignment, 2 page-invalid, 3 page-read-only |
| fault_addr | output | 32 | Word address that faulted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request completes this cycle |
| pt_wr_en | input | 1 | Page-table maintenance write |
| pt_wr_idx | input | 4 | Entry to write |
| pt_wr_valid | input | 1 | New valid flag |
| pt_wr_writable | input | 1 | New writable flag |
| pt_rd_idx | input | 4 | Entry to observe |
| pt_rd_flags | output | 4 | {valid, writable, referenced, dirty} of the observed entry |

## Verification
The assertions check several properties on every cycle:
- `done` and `fault` never coincide, and a fault always carries a non-zero code.
- A waiting memory request holds its address, direction and data stable.
- No request ever uses a misaligned address.
- A write reaches memory only on a page already marked dirty.
- A completed read leaves its page referenced.

The bench scenarios show behaviour that no single-cycle property can:
- Word order in memory and in the result.
- Page-table flags left behind by a fault on the second page of a load or a store.
- The absence of writes after such a fault.
- Alignment faults that touch nothing.
- Start pulses dropped while the block is busy.

// File: rtl/dword_xfer_seq.sv
module dword_xfer_seq #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int NUM_PAGES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         cmd_store,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [63:0]                  wdata,
  output logic                         done,
  output logic [63:0]                  rdata,
  output logic                         fault,
  output logic [1:0]                   fault_code,
  output logic [ADDR_W-1:0]            fault_addr,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [31:0]                  mem_wdata,
  input  logic [31:0]                  mem_rdata,
  input  logic                         mem_ready,
  input  logic                         pt_wr_en,
  input  logic [$clog2(NUM_PAGES)-1:0] pt_wr_idx,
  input  logic                         pt_wr_valid,
  input  logic                         pt_wr_writable,
  input  logic [$clog2(NUM_PAGES)-1:0] pt_rd_idx,
  output logic [3:0]                   pt_rd_flags
);
  localparam int IDX_W = $clog2(NUM_PAGES);
  localparam int VPN_W = ADDR_W - PAGE_BITS;

  localparam logic [1:0] FC_ALIGN = 2'd1;
  localparam logic [1:0] FC_INV   = 2'd2;
  localparam logic [1:0] FC_RO    = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_LT0, S_LR0, S_LT1, S_LR1, S_STC, S_SW0, S_SW1
  } state_t;

  state_t             st;
  logic [ADDR_W-1:0]  base;
  logic [63:0]        wd;
  logic [31:0]        hi;
  logic [NUM_PAGES-1:0] valid_q, wr_q, ref_q, dirty_q;

  logic [ADDR_W-1:0]  a1;
  logic [VPN_W-1:0]   vpn0, vpn1;
  logic [IDX_W-1:0]   idx0, idx1, req_idx;
  logic               v0, v1, w0, w1;
  logic               set_ref, set_d0, set_d1, xfer;

  assign a1   = base + ADDR_W'(4);
  assign vpn0 = base[ADDR_W-1:PAGE_BITS];
  assign vpn1 = a1[ADDR_W-1:PAGE_BITS];
  assign idx0 = vpn0[IDX_W-1:0];
  assign idx1 = vpn1[IDX_W-1:0];
  assign v0   = ~|vpn0[VPN_W-1:IDX_W] & valid_q[idx0];
  assign v1   = ~|vpn1[VPN_W-1:IDX_W] & valid_q[idx1];
  assign w0   = v0 & wr_q[idx0];
  assign w1   = v1 & wr_q[idx1];

  assign mem_req   = (st == S_LR0) || (st == S_LR1) || (st == S_SW0) || (st == S_SW1);
  assign mem_we    = (st == S_SW0) || (st == S_SW1);
  assign mem_addr  = ((st == S_LR1) || (st == S_SW1)) ? a1 : base;
  assign mem_wdata = (st == S_SW1) ? wd[31:0] : wd[63:32];
  assign xfer      = mem_req & mem_ready;

  assign req_idx = mem_addr[PAGE_BITS +: IDX_W];
  assign set_ref = xfer & ~mem_we;
  assign set_d0  = (st == S_STC) & w0;
  assign set_d1  = (st == S_STC) & w0 & w1;

  assign pt_rd_flags = {valid_q[pt_rd_idx], wr_q[pt_rd_idx], ref_q[pt_rd_idx], dirty_q[pt_rd_idx]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      wr_q    <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        if (pt_wr_en && pt_wr_idx == IDX_W'(i)) begin
          valid_q[i] <= pt_wr_valid;
          wr_q[i]    <= pt_wr_writable;
          ref_q[i]   <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else begin
          if (set_ref && req_idx == IDX_W'(i)) ref_q[i] <= 1'b1;
          if ((set_d0 && idx0 == IDX_W'(i)) || (set_d1 && idx1 == IDX_W'(i)))
            dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base       <= '0;
      wd         <= '0;
      hi         <= '0;
      rdata      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      fault_addr <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          base <= addr;
          wd   <= wdata;
          if (addr[1:0] != 2'b00) begin
            fault      <= 1'b1;
            fault_code <= FC_ALIGN;
            fault_addr <= addr;
          end else begin
            st <= cmd_store ? S_STC : S_LT0;
          end
        end
        S_LT0: if (!v0) begin
          fault <= 1'b1; fault_code <= FC_INV; fault_addr <= base; st <= S_IDLE;
        end else st <= S_LR0;
        S_LR0: if (mem_ready) begin
          hi <= mem_rdata;
          st <= S_LT1;
        end
        S_LT1: if (!v1) begin
          fault <= 1'b1; fault_code <= FC_INV; fault_addr <= a1; st <= S_IDLE;
        end else st <= S_LR1;
        S_LR1: if (mem_ready) begin
          rdata <= {hi, mem_rdata};
          done  <= 1'b1;
          st    <= S_IDLE;
        end
        S_STC: begin
          if (!v0) begin
            fault <= 1'b1; fault_code <= FC_INV; fault_addr <= base; st <= S_IDLE;
          end else if (!w0) begin
            fault <= 1'b1; fault_code <= FC_RO; fault_addr <= base; st <= S_IDLE;
          end else if (!v1) begin
            fault <= 1'b1; fault_code <= FC_INV; fault_addr <= a1; st <= S_IDLE;
          end else if (!w1) begin
            fault <= 1'b1; fault_code <= FC_RO; fault_addr <= a1; st <= S_IDLE;
          end else st <= S_SW0;
        end
        S_SW0: if (mem_ready) st <= S_SW1;
        S_SW1: if (mem_ready) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dword_xfer_seq_chk.sv
module dword_xfer_seq_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int NUM_PAGES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic                 fault,
  input logic [1:0]           fault_code,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 mem_ready,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [31:0]          mem_wdata,
  input logic                 pt_wr_en,
  input logic [NUM_PAGES-1:0] ref_q,
  input logic [NUM_PAGES-1:0] dirty_q
);
  localparam int IDX_W = $clog2(NUM_PAGES);

  logic [IDX_W-1:0] last_idx;
  always_ff @(posedge clk) last_idx <= mem_addr[PAGE_BITS +: IDX_W];

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_FAULT_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n) fault |-> fault_code != 2'd0); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R2
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00); // R8
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> dirty_q[mem_addr[PAGE_BITS +: IDX_W]]); // R5
  AST_READ_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_we && !pt_wr_en |=> ref_q[last_idx]); // R3
endmodule

bind dword_xfer_seq dword_xfer_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fault(fault), .fault_code(fault_code),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .pt_wr_en(pt_wr_en), .ref_q(ref_q), .dirty_q(dirty_q)
);

// File: tb/test_dword_xfer_seq.sv
module test_dword_xfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 0, cmd_store = 0;
  logic [31:0] addr = 0;
  logic [63:0] wdata = 0;
  logic        done, fault, mem_req, mem_we;
  logic [63:0] rdata;
  logic [1:0]  fault_code;
  logic [31:0] fault_addr, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;
  logic        pt_wr_en = 0, pt_wr_valid = 0, pt_wr_writable = 0;
  logic [3:0]  pt_wr_idx = 0, pt_rd_idx = 0;
  logic [3:0]  pt_rd_flags;

  dword_xfer_seq i_dword_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_store(cmd_store), .addr(addr),
    .wdata(wdata), .done(done), .rdata(rdata), .fault(fault), .fault_code(fault_code),
    .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx), .pt_wr_valid(pt_wr_valid),
    .pt_wr_writable(pt_wr_writable), .pt_rd_idx(pt_rd_idx), .pt_rd_flags(pt_rd_flags)
  );

  // memory model: ready one cycle after request, every other cycle
  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  int          wcount = 0;
  logic        rdy = 1'b0;
  function automatic int midx(input logic [31:0] a);
    return int'({a[16:13], a[5:2]});
  endfunction
  assign mem_ready = rdy;
  assign mem_rdata = mem[midx(mem_addr)];
  always_ff @(posedge clk) begin
    rdy <= rst_n && mem_req && !rdy;
    if (mem_req && mem_ready && mem_we) begin
      mem[midx(mem_addr)] <= mem_wdata;
      wcount <= wcount + 1;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_page(input int p, input logic v, input logic w);
    @(negedge clk);
    pt_wr_en = 1; pt_wr_idx = 4'(p); pt_wr_valid = v; pt_wr_writable = w;
    @(negedge clk);
    pt_wr_en = 0;
  endtask

  function automatic logic [3:0] flags(input int p);
    pt_rd_idx = 4'(p);
    return 4'bx;
  endfunction

  task automatic get_flags(input int p, output logic [3:0] f);
    pt_rd_idx = 4'(p);
    #1 f = pt_rd_flags;
  endtask

  // result: 0 done, 1..3 fault code, 7 timeout
  task automatic run_op(input logic s, input logic [31:0] a, input logic [63:0] d,
                        output logic [2:0] res, output logic [31:0] fa);
    @(negedge clk);
    start = 1; cmd_store = s; addr = a; wdata = d;
    @(negedge clk);
    start = 0;
    res = 3'd7; fa = 0;
    for (int t = 0; t < 40; t++) begin
      if (done) begin res = 3'd0; break; end
      if (fault) begin res = {1'b0, fault_code}; fa = fault_addr; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        st;
    logic [31:0] a;
    logic [2:0]  res;
    logic [31:0] fa;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 32'h0000_0010, 3'd0, 32'h0},          // R2 store inside page 0
    '{1'b0, 32'h0000_0010, 3'd0, 32'h0},          // R1 load it back
    '{1'b1, 32'h0000_1FFC, 3'd0, 32'h0},          // R2 store across pages 0/1
    '{1'b0, 32'h0000_1FFC, 3'd0, 32'h0},          // R1 load across pages
    '{1'b0, 32'h0000_4000, 3'd0, 32'h0},          // R7 load from read-only page
    '{1'b1, 32'h0000_4000, 3'd3, 32'h0000_4000},  // R7 store to read-only page
    '{1'b0, 32'h0000_6000, 3'd2, 32'h0000_6000},  // R6 invalid page
    '{1'b0, 32'h0000_0012, 3'd1, 32'h0000_0012},  // R8 misaligned
    '{1'b0, 32'h0002_8000, 3'd2, 32'h0002_8000},  // R6 page number 20
    '{1'b1, 32'h0000_9FFC, 3'd3, 32'h0000_A000}   // R5 second page read-only
  };

  logic [2:0]  res;
  logic [31:0] fa;
  logic [3:0]  f;
  logic [63:0] d, old_rd;
  int          wc0, ndone;
  logic        wd_expired = 0;

  initial begin
    #1600000;
    wd_expired = 1;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h1000_0000 + i;
      exp_mem[i] = 32'h1000_0000 + i;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", done, 0);
    chk("R12 fault", fault, 0);
    chk("R12 mem_req", mem_req, 0);
    get_flags(0, f); chk("R12 flags", f, 4'b0000);
    rst_n = 1;

    set_page(0, 1, 1); set_page(1, 1, 1); set_page(2, 1, 0);
    set_page(3, 0, 1); set_page(4, 1, 1); set_page(5, 1, 0);
    get_flags(2, f); chk("R11 flags after write", f, 4'b1000);

    for (int i = 0; i < 10; i++) begin
      d = {32'hA500_0000 + 32'(i), 32'h005A_0000 + 32'(i * 3)};
      wc0 = wcount;
      run_op(VEC[i].st, VEC[i].a, d, res, fa);
      chk($sformatf("R9 vec%0d result", i), res, VEC[i].res);
      if (VEC[i].res != 0) begin
        chk($sformatf("R6 vec%0d fault_addr", i), fa, VEC[i].fa);
        #1 chk($sformatf("R5 vec%0d no write", i), wcount - wc0, 0);
      end else if (VEC[i].st) begin
        exp_mem[midx(VEC[i].a)] = d[63:32];
        exp_mem[midx(VEC[i].a + 4)] = d[31:0];
        chk($sformatf("R2 vec%0d upper word", i), mem[midx(VEC[i].a)], d[63:32]);
        chk($sformatf("R2 vec%0d lower word", i), mem[midx(VEC[i].a + 4)], d[31:0]);
      end else begin
        chk($sformatf("R1 vec%0d rdata", i), rdata,
            {exp_mem[midx(VEC[i].a)], exp_mem[midx(VEC[i].a + 4)]});
      end
    end

    get_flags(1, f); chk("R3 page1 ref+dirty", f, 4'b1111);
    get_flags(2, f); chk("R3 read-only page referenced", f, 4'b1010);
    get_flags(4, f); chk("R5 first page dirty", f, 4'b1101);
    get_flags(5, f); chk("R5 second page clean", f, 4'b1000);

    // R4 load faulting on second page
    set_page(2, 1, 0);
    old_rd = rdata;
    run_op(0, 32'h0000_5FFC, 64'h0, res, fa);
    chk("R4 result", res, 3'd2);
    chk("R4 fault_addr", fa, 32'h0000_6000);
    chk("R4 rdata kept", rdata, old_rd);
    get_flags(2, f); chk("R4 first page referenced", f, 4'b1010);

    // R8 misaligned store touches nothing
    set_page(0, 1, 1);
    wc0 = wcount;
    run_op(1, 32'h0000_0002, 64'h1, res, fa);
    chk("R8 code", res, 3'd1);
    get_flags(0, f); chk("R8 flags untouched", f, 4'b1100);
    chk("R8 no write", wcount - wc0, 0);

    // R10 start while busy ignored
    wc0 = wcount;
    @(negedge clk);
    start = 1; cmd_store = 0; addr = 32'h10; wdata = 0;
    @(negedge clk);
    start = 1; cmd_store = 1; addr = 32'h1FFC; wdata = 64'hDEAD;
    @(negedge clk);
    start = 0;
    ndone = 0;
    for (int t = 0; t < 30; t++) begin
      if (done) ndone++;
      @(negedge clk);
    end
    chk("R10 single done", ndone, 1);
    chk("R10 no write", wcount - wc0, 0);
    chk("R10 rdata", rdata, {exp_mem[midx(32'h10)], exp_mem[midx(32'h14)]});

    if (wd_expired) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (wd_expired);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule